// File: doc/BRIEF.md
# Multi-Channel Hardware Mutex Lock Unit

This block holds a small bank of hardware mutexes shared by a set of command channels and the CPU. Each channel presents one command word per cycle. A word carrying the extended opcode with sub-opcode 0 asks for a lock, and sub-opcode 1 gives one back. The lock number sits in the low byte. The CPU has a direct acquire/release port with its own 8-bit index. For every lock the unit records whether it is free, held by the CPU, or held by a channel, and for a channel holder it also records which channel. All of this is visible on flat status outputs.

A requester that asks for a held lock sees its stall output high in the same cycle. It keeps presenting the request until the stall drops, which happens in the first cycle that it finds the lock free and wins arbitration. Contention within one cycle is resolved by fixed priority: the CPU first, then channel 0, then channel 1, and so on. Releases are honoured only from the current holder. Bad releases and out-of-range indices set sticky error flags, which stay set until reset.

Top module: `mlock_unit`

## Requirements
- R1: After synchronous reset every lock is free, all status outputs are zero, both error flags are low, and no stall is raised while no request is present.
- R2: Each lock is in exactly one of three states: free, CPU-held, or channel-held. The status outputs give a channel-holds flag and a CPU-holds flag per lock, plus a CH_W-bit holder field at bits [l*CH_W +: CH_W]. The holder field is the channel number when the lock is channel-held and zero otherwise.
- R3: A channel word is a lock request only when its valid bit is high and bits [31:28] equal 0xE. Bits [27:24] select the sub-opcode (0 = acquire, 1 = release) and bits [7:0] carry the lock index. Every other word, and any word whose valid bit is low, changes no state and raises no stall or error.
- R4: An acquire of a free lock that wins arbitration keeps the requester's stall low in the cycle it is presented. The status shows the new holder from the next cycle.
- R5: While the requested lock is held, the acquiring requester's stall stays high. The acquire is granted in the first cycle the lock is seen free.
- R6: When several acquires target the same free lock in one cycle, the CPU wins over all channels and a lower channel number wins over a higher one. Every loser sees its stall high.
- R7: A request with an index at or above NUM_LOCKS changes no lock, raises no stall, and sets the sticky index-error flag from the next cycle.
- R8: A release from the current holder frees the lock from the next cycle. A release from any other requester, or of a free lock, changes nothing and sets the sticky release-error flag.
- R9: If a release by the holder and an acquire by another requester hit the same lock in one cycle, the acquirer is stalled in that cycle and granted in the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_vld | input | NUM_CH | Per-channel command word valid |
| ch_cmd | input | NUM_CH*32 | Per-channel command words, channel c at [c*32 +: 32] |
| ch_stall | output | NUM_CH | Per-channel acquire stall |
| cpu_acq | input | 1 | CPU acquire request |
| cpu_rel | input | 1 | CPU release request |
| cpu_idx | input | 8 | CPU lock index |
| cpu_stall | output | 1 | CPU acquire stall |
| st_ch_owns | output | NUM_LOCKS | Lock held by a channel |
| st_cpu_owns | output | NUM_LOCKS | Lock held by the CPU |
| st_owner | output | NUM_LOCKS*CH_W | Holder channel number per lock |
| err_release | output | 1 | Sticky bad-release flag |
| err_index | output | 1 | Sticky out-of-range index flag |

## Verification
Stall outputs are combinational in the request and the current lock state, so they are due in the same cycle as the request. Lock status and both error flags are registered and are due one rising edge later. The bench drives every stimulus on a falling edge and reads the stalls 1 ns later. It reads status and error flags only after the following falling edge, so each read comes exactly one register stage after the request that caused it. Holding requests across several edges shows the stall persisting over successive cycles and then dropping on the cycle the lock frees.

// File: rtl/mlock_pkg.sv
package mlock_pkg;
  typedef enum logic [1:0] {
    LK_FREE = 2'd0,
    LK_CH   = 2'd1,
    LK_CPU  = 2'd2
  } lk_state_t;

  localparam int          IDX_W   = 8;
  localparam int          CMD_W   = 32;
  localparam logic [3:0]  OP_EXT  = 4'hE;
  localparam logic [3:0]  SUB_ACQ = 4'h0;
  localparam logic [3:0]  SUB_REL = 4'h1;
endpackage

// File: rtl/mlock_decode.sv
module mlock_decode
  import mlock_pkg::*;
(
  input  logic             vld,
  input  logic [CMD_W-1:0] cmd,
  output logic             acq,
  output logic             rel,
  output logic [IDX_W-1:0] idx
);
  logic is_ext;

  always_comb begin
    is_ext = vld && (cmd[31:28] == OP_EXT);
    acq    = is_ext && (cmd[27:24] == SUB_ACQ);
    rel    = is_ext && (cmd[27:24] == SUB_REL);
    idx    = cmd[IDX_W-1:0];
  end
endmodule

// File: rtl/mlock_pick.sv
module mlock_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic seen;

  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !seen;
      seen   = seen || req[i];
    end
  end
endmodule

// File: rtl/mlock_cell.sv
module mlock_cell
  import mlock_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] acq_vec,
  input  logic [NREQ-1:0] rel_vec,
  output logic [NREQ-1:0] grant_vec,
  output logic            rel_bad,
  output logic            ch_owns,
  output logic            cpu_owns,
  output logic [CH_W-1:0] owner
);
  lk_state_t       st;
  logic [CH_W-1:0] own;
  logic [NREQ-1:0] first;
  logic [NREQ-1:0] holder_vec;
  logic            rel_hit;
  logic [CH_W-1:0] win;

  mlock_pick #(.N(NREQ)) u_pick (.req(acq_vec), .gnt(first));

  genvar r;
  generate
    for (r = 0; r < NREQ; r++) begin : g_hold
      if (r == 0) begin : g_cpu
        assign holder_vec[r] = (st == LK_CPU);
      end else begin : g_ch
        assign holder_vec[r] = (st == LK_CH) && (own == CH_W'(r - 1));
      end
    end
  endgenerate

  always_comb begin
    grant_vec = (st == LK_FREE) ? first : '0;
    rel_hit   = |(rel_vec & holder_vec);
    rel_bad   = |(rel_vec & ~holder_vec);
    win       = '0;
    for (int k = NREQ - 1; k >= 1; k--) begin
      if (first[k]) win = CH_W'(k - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= LK_FREE;
      own <= '0;
    end else if (rel_hit) begin
      st  <= LK_FREE;
      own <= '0;
    end else if (|grant_vec) begin
      if (grant_vec[0]) begin
        st  <= LK_CPU;
        own <= '0;
      end else begin
        st  <= LK_CH;
        own <= win;
      end
    end
  end

  assign ch_owns  = (st == LK_CH);
  assign cpu_owns = (st == LK_CPU);
  assign owner    = own;
endmodule

// File: rtl/mlock_unit.sv
module mlock_unit
  import mlock_pkg::*;
#(
  parameter int NUM_LOCKS = 4,
  parameter int NUM_CH    = 3,
  parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         ch_vld,
  input  logic [NUM_CH*32-1:0]      ch_cmd,
  output logic [NUM_CH-1:0]         ch_stall,
  input  logic                      cpu_acq,
  input  logic                      cpu_rel,
  input  logic [7:0]                cpu_idx,
  output logic                      cpu_stall,
  output logic [NUM_LOCKS-1:0]      st_ch_owns,
  output logic [NUM_LOCKS-1:0]      st_cpu_owns,
  output logic [NUM_LOCKS*CH_W-1:0] st_owner,
  output logic                      err_release,
  output logic                      err_index
);
  localparam int NREQ = NUM_CH + 1;

  logic [NREQ-1:0]  rq_acq, rq_rel, rq_ok, granted, stall;
  logic [IDX_W-1:0] rq_idx [NREQ];
  logic [NREQ-1:0]  gnt_l  [NUM_LOCKS];
  logic [NUM_LOCKS-1:0] bad_l;

  assign rq_acq[0] = cpu_acq;
  assign rq_rel[0] = cpu_rel;
  assign rq_idx[0] = cpu_idx;

  genvar c, l, r;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_dec
      mlock_decode u_dec (
        .vld (ch_vld[c]),
        .cmd (ch_cmd[c*CMD_W +: CMD_W]),
        .acq (rq_acq[c+1]),
        .rel (rq_rel[c+1]),
        .idx (rq_idx[c+1])
      );
    end

    for (r = 0; r < NREQ; r++) begin : g_ok
      assign rq_ok[r] = ({1'b0, rq_idx[r]} < (IDX_W+1)'(NUM_LOCKS));
    end

    for (l = 0; l < NUM_LOCKS; l++) begin : g_lock
      logic [NREQ-1:0] acq_v, rel_v;
      always_comb begin
        for (int k = 0; k < NREQ; k++) begin
          acq_v[k] = rq_acq[k] && rq_ok[k] && (rq_idx[k] == IDX_W'(l));
          rel_v[k] = rq_rel[k] && rq_ok[k] && (rq_idx[k] == IDX_W'(l));
        end
      end
      mlock_cell #(.NREQ(NREQ), .CH_W(CH_W)) u_cell (
        .clk       (clk),
        .rst       (rst),
        .acq_vec   (acq_v),
        .rel_vec   (rel_v),
        .grant_vec (gnt_l[l]),
        .rel_bad   (bad_l[l]),
        .ch_owns   (st_ch_owns[l]),
        .cpu_owns  (st_cpu_owns[l]),
        .owner     (st_owner[l*CH_W +: CH_W])
      );
    end
  endgenerate

  always_comb begin
    granted = '0;
    for (int k = 0; k < NUM_LOCKS; k++) granted = granted | gnt_l[k];
    stall = rq_acq & rq_ok & ~granted;
  end

  assign cpu_stall = stall[0];
  assign ch_stall  = stall[NREQ-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_release <= 1'b0;
      err_index   <= 1'b0;
    end else begin
      err_release <= err_release | (|bad_l);
      err_index   <= err_index | (|((rq_acq | rq_rel) & ~rq_ok));
    end
  end
endmodule

// File: rtl/mlock_unit_chk.sv
module mlock_unit_chk #(
  parameter int NUM_LOCKS = 4,
  parameter int NUM_CH    = 3,
  parameter int CH_W      = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CH-1:0]         ch_vld,
  input logic [NUM_CH*32-1:0]      ch_cmd,
  input logic [NUM_CH-1:0]         ch_stall,
  input logic                      cpu_acq,
  input logic                      cpu_rel,
  input logic [7:0]                cpu_idx,
  input logic                      cpu_stall,
  input logic [NUM_LOCKS-1:0]      st_ch_owns,
  input logic [NUM_LOCKS-1:0]      st_cpu_owns,
  input logic [NUM_LOCKS*CH_W-1:0] st_owner,
  input logic                      err_release,
  input logic                      err_index
);
  localparam int LK_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

  logic            cpu_in_rng;
  logic [LK_W-1:0] cpu_li;
  assign cpu_in_rng = ({1'b0, cpu_idx} < 9'(NUM_LOCKS));
  assign cpu_li     = LK_W'(cpu_idx);

  p_cpu_first_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_acq && cpu_in_rng && !st_ch_owns[cpu_li] && !st_cpu_owns[cpu_li]) |-> !cpu_stall);

  p_bad_index_r7: assert property (@(posedge clk) disable iff (rst)
    ((cpu_acq || cpu_rel) && !cpu_in_rng) |=> err_index);

  p_idx_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_index |=> err_index);

  p_rel_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_release |=> err_release);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [31:0]     w;
      logic            take, take_q;
      logic [LK_W-1:0] li_q;
      assign w    = ch_cmd[c*32 +: 32];
      assign take = ch_vld[c] && (w[31:24] == 8'hE0) &&
                    ({1'b0, w[7:0]} < 9'(NUM_LOCKS)) && !ch_stall[c];
      always_ff @(posedge clk) begin
        if (rst) begin
          take_q <= 1'b0;
          li_q   <= '0;
        end else begin
          take_q <= take;
          li_q   <= LK_W'(w[7:0]);
        end
      end
      p_grant_owns_r4: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (st_ch_owns[li_q] &&
                    st_owner[int'(li_q)*CH_W +: CH_W] == CH_W'(c)));
    end
  endgenerate
endmodule

bind mlock_unit mlock_unit_chk #(
  .NUM_LOCKS(NUM_LOCKS), .NUM_CH(NUM_CH), .CH_W(CH_W)
) u_chk (.*);

// File: tb/sim_mlock_unit.sv
`timescale 1ns/1ps
module sim_mlock_unit;
  localparam int NL = 4;
  localparam int NC = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst;
  logic [NC-1:0]    ch_vld;
  logic [NC*32-1:0] ch_cmd;
  logic [NC-1:0]    ch_stall;
  logic cpu_acq, cpu_rel, cpu_stall;
  logic [7:0] cpu_idx;
  logic [NL-1:0] st_ch_owns, st_cpu_owns;
  logic [NL*CW-1:0] st_owner;
  logic err_release, err_index;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mlock_unit #(.NUM_LOCKS(NL), .NUM_CH(NC)) u0 (.*);

  function automatic logic [31:0] mk(input logic [3:0] sub, input logic [7:0] idx);
    return {4'hE, sub, 16'h0000, idx};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_lock(input string tag, input int l, input int chv, input int cpuv, input int own);
    check({tag, " ch_owns"},  int'(st_ch_owns[l]), chv);
    check({tag, " cpu_owns"}, int'(st_cpu_owns[l]), cpuv);
    check({tag, " owner"},    int'(st_owner[l*CW +: CW]), own);
  endtask

  task automatic set_ch(input int c, input logic v, input logic [31:0] w);
    ch_vld[c] = v;
    ch_cmd[c*32 +: 32] = w;
  endtask

  task automatic idle();
    ch_vld = '0; ch_cmd = '0; cpu_acq = 0; cpu_rel = 0; cpu_idx = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; idle(); tick(); tick(); rst = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 ch_owns", int'(st_ch_owns), 0);
    check("R1 cpu_owns", int'(st_cpu_owns), 0);
    check("R1 owner", int'(st_owner), 0);
    check("R1 errs", int'({err_release, err_index}), 0);
    check("R1 stalls", int'({ch_stall, cpu_stall}), 0);

    // R4 R8 R2: sweep every lock against every requester
    for (int l = 0; l < NL; l++) begin
      for (int r = 0; r <= NC; r++) begin
        if (r == 0) begin cpu_acq = 1; cpu_idx = 8'(l); end
        else set_ch(r - 1, 1, mk(4'h0, 8'(l)));
        #1;
        check("R4 no stall on free lock", int'({ch_stall, cpu_stall}), 0);
        tick(); idle();
        chk_lock("R2 R4 holder", l, (r != 0), (r == 0), (r == 0) ? 0 : r - 1);
        if (r == 0) begin cpu_rel = 1; cpu_idx = 8'(l); end
        else set_ch(r - 1, 1, mk(4'h1, 8'(l)));
        tick(); idle();
        chk_lock("R8 freed by holder", l, 0, 0, 0);
      end
    end
    check("R8 no error from holders", int'(err_release), 0);

    // R6 contention on lock 2
    cpu_acq = 1; cpu_idx = 2;
    for (int c = 0; c < NC; c++) set_ch(c, 1, mk(4'h0, 8'd2));
    #1;
    check("R6 cpu wins", int'(cpu_stall), 0);
    check("R6 channels lose", int'(ch_stall), 3'b111);
    tick();
    chk_lock("R6 cpu holds", 2, 0, 1, 0);
    cpu_acq = 0; cpu_rel = 1;
    #1;
    check("R9 acquirers stall during release", int'(ch_stall), 3'b111);
    tick(); cpu_rel = 0; #1;
    check("R5 R6 ch0 granted after free", int'(ch_stall), 3'b110);
    tick();
    chk_lock("R6 ch0 holds", 2, 1, 0, 0);
    set_ch(0, 1, mk(4'h1, 8'd2));
    #1;
    check("R5 others still stall", int'(ch_stall), 3'b110);
    tick(); set_ch(0, 0, 32'h0); #1;
    check("R6 ch1 beats ch2", int'(ch_stall), 3'b100);
    tick(); idle();
    chk_lock("R6 ch1 holds", 2, 1, 0, 1);
    check("R8 err clear so far", int'(err_release), 0);

    // R8 release by non-holders
    set_ch(2, 1, mk(4'h1, 8'd2));
    tick(); idle();
    chk_lock("R8 foreign release ignored", 2, 1, 0, 1);
    check("R8 err set", int'(err_release), 1);
    cpu_rel = 1; cpu_idx = 2;
    tick(); idle();
    chk_lock("R8 cpu release ignored", 2, 1, 0, 1);

    // R7 out-of-range index
    check("R7 idx err clear", int'(err_index), 0);
    cpu_acq = 1; cpu_idx = 8'd4;
    set_ch(0, 1, mk(4'h0, 8'hFF));
    #1;
    check("R7 no stall", int'({ch_stall, cpu_stall}), 0);
    tick(); idle();
    check("R7 idx err set", int'(err_index), 1);
    check("R7 no change ch", int'(st_ch_owns), 4'b0100);
    check("R7 no change cpu", int'(st_cpu_owns), 0);
    tick();
    check("R7 sticky", int'(err_index), 1);

    // R3 non-lock words ignored
    do_reset();
    set_ch(0, 1, {4'h1, 4'h0, 16'h0, 8'd0});
    set_ch(1, 1, mk(4'h2, 8'd1));
    set_ch(2, 0, mk(4'h0, 8'd3));
    #1;
    check("R3 no stall", int'(ch_stall), 0);
    tick(); idle();
    check("R3 no owner", int'({st_ch_owns, st_cpu_owns}), 0);
    check("R3 no error", int'({err_release, err_index}), 0);

    // R8 release of free lock
    cpu_rel = 1; cpu_idx = 3;
    tick(); idle();
    check("R8 free-lock release err", int'(err_release), 1);
    chk_lock("R8 lock3 still free", 3, 0, 0, 0);

    // R5 CPU stalls on channel-held lock, then granted
    set_ch(1, 1, mk(4'h0, 8'd0));
    tick(); idle();
    cpu_acq = 1; cpu_idx = 0;
    for (int k = 0; k < 3; k++) begin
      #1; check("R5 cpu stalls while held", int'(cpu_stall), 1);
      tick();
    end
    set_ch(1, 1, mk(4'h1, 8'd0));
    #1; check("R9 cpu stalls on release cycle", int'(cpu_stall), 1);
    tick(); set_ch(1, 0, 32'h0);
    #1; check("R5 cpu granted", int'(cpu_stall), 0);
    tick(); idle();
    chk_lock("R5 cpu holds", 0, 0, 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule